// File: doc/BRIEF.md
# Exception Vector Entry Unit

This block performs the state update that happens when the processor takes an exception or an interrupt. It receives a strobe, a cause code, the function code of a call-firmware request, the current program counter, the firmware base register and the current privileged-mode flag. In the cycle after the strobe it presents the firmware entry address as the new program counter. It also presents the saved return address, with the old privileged-mode flag folded into bit 0, and the privileged-mode flag forced on.

Hardware causes go to fixed slots spaced 128 bytes apart from the firmware base. Call-firmware requests go to one of two computed regions, each with 64-byte slots. Codes with bit 7 clear land in the privileged region and codes with bit 7 set land in the unprivileged region. The unit only carries out the entry. Selecting which exception to raise is done elsewhere.

Top module: `exc_vector_unit`

## Requirements
- R1: After reset, `pc_o`, `exc_addr_o`, `priv_o` and `err_o` are all 0.
- R2: For a take with cause 0..9, `pc_o` becomes `fw_base_i + cause*0x80`. The encoding is 0 reset, 1 machine check, 2 interprocessor, 3 clock, 4 device, 5 memory fault, 6 unaligned, 7 illegal opcode, 8 arithmetic, 9 FP disabled.
- R3: For a take with cause 10 (call firmware) and `code_i[7]`=0, `pc_o` becomes `fw_base_i + 0x1000 + code_i*64`.
- R4: For a take with cause 10 and `code_i[7]`=1, `pc_o` becomes `fw_base_i + 0x2000 + (code_i-0x80)*64`.
- R5: On a valid take, `exc_addr_o` becomes `cur_pc_i` ORed with `priv_i` in bit 0.
- R6: On a valid take, `priv_o` becomes 1, whatever the value of `priv_i`.
- R7: A take with cause 11..15 raises `err_o` for one cycle. `pc_o`, `exc_addr_o` and `priv_o` keep their values.
- R8: Without a take, `err_o` is 0 and `pc_o`, `exc_addr_o` and `priv_o` keep their values.
- R9: Outputs are updated at the clock edge that samples `take_i` high, and a take in every cycle is handled in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| take_i | input | 1 | Take strobe |
| cause_i | input | 4 | Exception cause code |
| code_i | input | 8 | Call-firmware function code |
| cur_pc_i | input | AW | Current program counter |
| fw_base_i | input | AW | Firmware base address |
| priv_i | input | 1 | Current privileged-mode flag |
| pc_o | output | AW | New program counter |
| exc_addr_o | output | AW | Saved exception address |
| priv_o | output | 1 | Updated privileged-mode flag |
| err_o | output | 1 | Unknown cause seen on last take |

## Verification
The bench steps through every fixed cause. If the 128-byte stride is wrong, or the slot order is permuted, the new PC lands in the wrong slot. For call entries it uses the edge codes 0x00, 0x7F, 0x80 and 0xFF. A design that fails to subtract 0x80 for the unprivileged region would overshoot by 0x2000, and one that picks the region on the wrong bit would swap the two regions. Both values of the incoming privileged flag are driven so that a dropped or inverted bit 0 in the saved address shows up. Unknown causes and idle cycles are mixed between valid takes, and back-to-back takes are run, to catch a design that updates state on an error, that holds the error flag high, or that adds a cycle of latency.

// File: rtl/exc_vector_unit.sv
module exc_vector_unit #(
  parameter int AW = 64,
  parameter int CW = 8,
  parameter int NFIX = 10,
  parameter int FIX_STRIDE_LG = 7,
  parameter int CALL_STRIDE_LG = 6,
  parameter int PRIV_BASE = 'h1000,
  parameter int USER_BASE = 'h2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic [3:0]    cause_i,
  input  logic [CW-1:0] code_i,
  input  logic [AW-1:0] cur_pc_i,
  input  logic [AW-1:0] fw_base_i,
  input  logic          priv_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] exc_addr_o,
  output logic          priv_o,
  output logic          err_o
);
  localparam logic [3:0] CALL_CAUSE = 4'(NFIX);
  localparam int OW = 16;

  logic          is_fixed, is_call, valid;
  logic [OW-1:0] fix_off, call_off, off;

  assign is_fixed = cause_i < CALL_CAUSE;
  assign is_call  = cause_i == CALL_CAUSE;
  assign valid    = is_fixed | is_call;

  assign fix_off  = OW'(cause_i) << FIX_STRIDE_LG;
  assign call_off = code_i[CW-1]
                  ? OW'(USER_BASE) + (OW'(code_i[CW-2:0]) << CALL_STRIDE_LG)
                  : OW'(PRIV_BASE) + (OW'(code_i[CW-2:0]) << CALL_STRIDE_LG);
  assign off      = is_call ? call_off : fix_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o       <= '0;
      exc_addr_o <= '0;
      priv_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      err_o <= take_i & ~valid;
      if (take_i && valid) begin
        pc_o       <= fw_base_i + AW'(off);
        exc_addr_o <= {cur_pc_i[AW-1:1], cur_pc_i[0] | priv_i};
        priv_o     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk #(
  parameter int AW = 64,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          take_i,
  input logic [3:0]    cause_i,
  input logic [CW-1:0] code_i,
  input logic [AW-1:0] cur_pc_i,
  input logic [AW-1:0] fw_base_i,
  input logic          priv_i,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] exc_addr_o,
  input logic          priv_o,
  input logic          err_o
);
  AST_FIXED_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && cause_i < 4'd10) |=> (pc_o - $past(fw_base_i)) == (AW'($past(cause_i)) * 'h80)); // R2
  AST_CALL_PRIV_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && cause_i == 4'd10 && !code_i[CW-1]) |=> (pc_o - $past(fw_base_i)) < AW'('h3000) && (pc_o - $past(fw_base_i)) >= AW'('h1000)); // R3
  AST_CALL_USER_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && cause_i == 4'd10 && code_i[CW-1]) |=> (pc_o - $past(fw_base_i)) >= AW'('h2000) && (pc_o - $past(fw_base_i)) < AW'('h4000)); // R4
  AST_SAVED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && cause_i <= 4'd10) |=> exc_addr_o == ($past(cur_pc_i) | AW'($past(priv_i)))); // R5
  AST_PRIV_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && cause_i <= 4'd10) |=> priv_o && !err_o); // R6
  AST_BAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && cause_i > 4'd10) |=> err_o && $stable(pc_o) && $stable(exc_addr_o) && $stable(priv_o)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> !err_o && $stable(pc_o) && $stable(exc_addr_o) && $stable(priv_o)); // R8
endmodule

bind exc_vector_unit exc_vector_unit_chk #(.AW(AW), .CW(CW)) u_chk (.*);

// File: tb/exc_vector_unit_tb.sv
module exc_vector_unit_tb;
  logic        clk = 0, rst_n = 0;
  logic        take_i = 0, priv_i = 0;
  logic [3:0]  cause_i = 0;
  logic [7:0]  code_i = 0;
  logic [63:0] cur_pc_i = 0, fw_base_i = 0;
  logic [63:0] pc_o, exc_addr_o;
  logic        priv_o, err_o;
  int tests = 0, fails = 0;
  longint unsigned m_pc = 0, m_ea = 0;
  bit m_priv = 0, m_err = 0;

  always #5 clk = ~clk;

  exc_vector_unit u_dut (.*);

  task automatic chk(string r, longint unsigned act, longint unsigned exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic step(bit t, int c, int cd, longint unsigned pc, longint unsigned base, bit p, string r);
    longint unsigned off;
    @(negedge clk);
    take_i = t; cause_i = 4'(c); code_i = 8'(cd); cur_pc_i = pc; fw_base_i = base; priv_i = p;
    @(posedge clk); #1;
    m_err = 0;
    if (t) begin
      if (c <= 9 || c == 10) begin
        if (c <= 9) off = longint'(c) * 128;
        else if (cd >= 128) off = 'h2000 + longint'(cd - 128) * 64;
        else off = 'h1000 + longint'(cd) * 64;
        m_pc = base + off; m_ea = pc | longint'(p); m_priv = 1;
      end else m_err = 1;
    end
    chk({r, " pc"}, pc_o, m_pc);
    chk({r, " exc_addr"}, exc_addr_o, m_ea);
    chk({r, " priv"}, longint'(priv_o), longint'(m_priv));
    chk({r, " err"}, longint'(err_o), longint'(m_err));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #12;
    chk("R1 pc", pc_o, 0); chk("R1 exc_addr", exc_addr_o, 0);
    chk("R1 priv", longint'(priv_o), 0); chk("R1 err", longint'(err_o), 0);
    @(negedge clk); rst_n = 1;
    for (int c = 0; c < 10; c++)
      step(1, c, 8'h55, 64'h1000 + longint'(c) * 4, 64'hFFFF_0000_0010_0000, c[0], "R2");
    step(1, 10, 8'h00, 64'h4000, 64'h8000, 0, "R3");
    step(1, 10, 8'h01, 64'h4004, 64'h8000, 1, "R3");
    step(1, 10, 8'h7F, 64'h4008, 64'h8000, 0, "R3");
    step(1, 10, 8'h80, 64'h5000, 64'h8000, 1, "R4");
    step(1, 10, 8'h81, 64'h5004, 64'hC000, 0, "R4");
    step(1, 10, 8'hFF, 64'h5008, 64'hC000, 1, "R4");
    step(1, 3, 0, 64'hDEAD_BEE0, 64'h0, 1, "R5");
    step(1, 3, 0, 64'hDEAD_BEE1, 64'h0, 0, "R5");
    step(1, 5, 0, 64'h2000, 64'h100, 0, "R6");
    for (int c = 11; c < 16; c++)
      step(1, c, 8'h90, 64'h7777_0000, 64'h1234_0000, 0, "R7");
    step(0, 4, 8'h12, 64'h9990, 64'hAAA0, 0, "R8");
    step(0, 10, 8'h80, 64'h9994, 64'hBBB0, 1, "R8");
    step(1, 8, 0, 64'h100, 64'h0, 0, "R9");
    step(1, 10, 8'h20, 64'h104, 64'h10000, 1, "R9");
    step(1, 15, 0, 64'h108, 64'h0, 0, "R9");
    step(1, 1, 0, 64'h10C, 64'h20000, 0, "R9");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule